// File: doc/BRIEF.md
# Pixel Clock Numerically Controlled Oscillator

This block is a phase-accumulator oscillator clocked from the fixed 27 MHz video reference. A 24-bit accumulator adds the effective tuning word on every reference cycle. The accumulator's top bit is the reference waveform for the phase detector of an external PLL, and a one-cycle strobe marks each wrap of the accumulator. With 24 bits, one word step is worth about 1.6 Hz at the reference. The external PLL and its divider, which lift the output into the 27 to 85 MHz pixel clock range, are not part of this block.

Software loads a new tuning word a byte at a time into a staging register. The staged word has no effect on the running oscillator until a latch command arrives. Once the oscillator is running, the staged word is copied in on the next accumulator wrap. The accumulator is never cleared at a transfer, so the phase stays continuous and the frequency cannot change partway through a multi-byte update.

An optional dither adds a small offset of up to two LSBs to the active word. The offset comes from a free-running 16-bit LFSR that advances only once every few thousand reference cycles. This spreads the clock spectrum slowly enough for a narrow-band PLL, of about 5 kHz, to follow.

Top module: `nco_clk_synth`

## Requirements
- R1: After reset the active word, `freq_word`, `phase_msb`, `wrap_pulse` and `latch_pend` are all 0. They stay 0 until the first latch command has been transferred.
- R2: A write with `reg_wr_addr` = k (k = 0, 1, 2) loads `reg_wr_data` into bits 8k+7..8k of the staging word, so address 0 holds the low byte. Staging writes never change `freq_word` until a transfer takes place.
- R3: A write to an address of 3 or above leaves the staging word unchanged.
- R4: A one-cycle `latch_req` raises `latch_pend` after that edge. While the active word is zero, the staging word becomes active on the next edge, and `latch_pend` falls on that same edge.
- R5: While the active word is non-zero, a pending transfer takes place on the edge where the accumulator sum carries out. The new `freq_word` and `wrap_pulse` = 1 appear together, and `latch_pend` falls on that edge. A `latch_req` on that same edge keeps `latch_pend` high.
- R6: On each edge the accumulator becomes (accumulator + `freq_word`) mod 2^24. `phase_msb` is accumulator bit 23. `wrap_pulse` is 1 for exactly the cycle after an edge whose sum reached 2^24. While the active word is zero, the accumulator is held at 0.
- R7: A transfer does not reset the accumulator. The first addition with the new word starts from the sum left by the old word.
- R8: The dither LFSR is reset to 0xACE1 and shifts left once every `DITHER_DIV` reference edges, counted from the end of reset. The new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.
- R9: With `dither_en` = 1 and the active word A in [3, 2^24-3], `freq_word` = A + ((L mod 5) - 2), where L is the value of LFSR bits 2..0. Outside that range, `freq_word` = A.
- R10: With `dither_en` = 0, `freq_word` equals the active word exactly, whatever state the LFSR is in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Staging byte write strobe |
| reg_wr_addr | input | 2 | Staging byte index |
| reg_wr_data | input | 8 | Staging byte value |
| latch_req | input | 1 | One-cycle latch command |
| dither_en | input | 1 | Enables the dither offset |
| freq_word | output | 24 | Effective tuning word, including any dither offset |
| phase_msb | output | 1 | Accumulator MSB, the PLL phase reference |
| wrap_pulse | output | 1 | One-cycle strobe after each accumulator wrap |
| latch_pend | output | 1 | Latch command waiting for a transfer |

## Verification
Staging writes, `latch_req` and the accumulator all act on the same edge. `latch_pend` and the accumulator-derived outputs are due one cycle after the driving edge. A transfer from the idle state is due one edge after the latch command; from the running state it is due on the edge of the next accumulator carry. The bench drives inputs on the falling edge and keeps an arithmetic model that it advances on every rising edge. It compares all four outputs at the following falling edge, so each result is checked in exactly the cycle it is due. The dither offset is a combinational function of registered state and changes only on LFSR steps. The bench therefore counts edges since reset and samples halfway between steps, where the expected LFSR state is the seed stepped floor(count / `DITHER_DIV`) times.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] reg_byte_t;

endpackage

// File: rtl/nco_stage_regs.sv
module nco_stage_regs
    import nco_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  reg_byte_t         wr_data,
    output logic [ACC_W-1:0]  stage_word
);

    localparam int NUM_BYTES = (ACC_W + BYTE_W - 1) / BYTE_W;
    localparam int STAGE_W   = NUM_BYTES * BYTE_W;

    typedef struct packed {
        logic [STAGE_W-1:0] stage;
    } stage_t;

    stage_t state_d, state_q;
    logic [NUM_BYTES-1:0] byte_hit;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_hit
        assign byte_hit[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_hit[i]) begin
                state_d.stage[i*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stage_word = state_q.stage[ACC_W-1:0];

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q.stage)); // R2

    AST_STAGE_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NUM_BYTES))) |=> $stable(state_q.stage)); // R3

endmodule

// File: rtl/nco_dither_gen.sv
module nco_dither_gen #(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
    parameter int               DIV    = 4096,
    parameter int               AMP    = 2,
    parameter int               OFF_W  = $clog2(2*AMP+1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [OFF_W-1:0] dither_off
);

    localparam int MOD      = 2*AMP + 1;
    localparam int OFF_BITS = $clog2(MOD);
    localparam int DIV_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [LFSR_W-1:0] lfsr;
    } dith_t;

    dith_t state_d, state_q;
    int    sel_mod;

    always_comb begin
        state_d = state_q;
        if (state_q.div == DIV_LAST) begin
            state_d.div  = '0;
            state_d.lfsr = {state_q.lfsr[LFSR_W-2:0], ^(state_q.lfsr & TAPS)};
        end else begin
            state_d.div = state_q.div + 1'b1;
        end
        sel_mod    = int'(state_q.lfsr[OFF_BITS-1:0]) % MOD;
        dither_off = OFF_W'(sel_mod - AMP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.div  <= '0;
            state_q.lfsr <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.lfsr != '0); // R8

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.div != DIV_LAST) |=> $stable(state_q.lfsr)); // R8

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
    parameter int ACC_W = 24,
    parameter int AMP   = 2,
    parameter int OFF_W = $clog2(2*AMP+1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        stage_word,
    input  logic                    latch_req,
    input  logic                    dither_en,
    input  logic signed [OFF_W-1:0] dither_off,
    output logic [ACC_W-1:0]        freq_word,
    output logic                    phase_msb,
    output logic                    wrap_pulse,
    output logic                    latch_pend
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] AMP_W   = ACC_W'(AMP);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] active;
        logic             pend;
        logic             wrap;
    } core_t;

    core_t            state_d, state_q;
    logic             idle;
    logic             in_range;
    logic [ACC_W-1:0] off_ext;
    logic [ACC_W-1:0] eff_word;
    logic [ACC_W:0]   acc_sum;
    logic             carry;
    logic             xfer;

    always_comb begin
        idle     = (state_q.active == '0);
        in_range = (state_q.active > AMP_W) && (state_q.active <= ACC_MAX - AMP_W);
        off_ext  = {{(ACC_W-OFF_W){dither_off[OFF_W-1]}}, dither_off};
        eff_word = (dither_en && in_range) ? state_q.active + off_ext : state_q.active;
        acc_sum  = {1'b0, state_q.acc} + {1'b0, eff_word};
        carry    = acc_sum[ACC_W];
        xfer     = state_q.pend && (carry || idle);

        state_d        = state_q;
        state_d.acc    = idle ? '0 : acc_sum[ACC_W-1:0];
        state_d.wrap   = carry;
        state_d.active = xfer ? stage_word : state_q.active;
        state_d.pend   = latch_req || (state_q.pend && !xfer);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign freq_word  = eff_word;
    assign phase_msb  = state_q.acc[ACC_W-1];
    assign wrap_pulse = state_q.wrap;
    assign latch_pend = state_q.pend;

    AST_WORD_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q.active) |-> $past(state_q.pend)); // R5

    AST_XFER_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(state_q.pend) && ($past(state_q.active) != '0)) |-> state_q.wrap); // R5

    AST_IDLE_ACC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q.active) == '0) |-> (state_q.acc == '0)); // R6

    AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((freq_word - state_q.active + AMP_W) <= ACC_W'(2*AMP))); // R9

endmodule

// File: rtl/nco_clk_synth.sv
module nco_clk_synth
    import nco_pkg::*;
#(
    parameter int                ACC_W      = 24,
    parameter int                ADDR_W     = 2,
    parameter int                LFSR_W     = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1,
    parameter int                DITHER_DIV = 4096,
    parameter int                DITHER_AMP = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic              latch_req,
    input  logic              dither_en,
    output logic [ACC_W-1:0]  freq_word,
    output logic              phase_msb,
    output logic              wrap_pulse,
    output logic              latch_pend
);

    localparam int OFF_W = $clog2(2*DITHER_AMP+1) + 1;

    logic [ACC_W-1:0]        stage_word;
    logic signed [OFF_W-1:0] dither_off;

    nco_stage_regs #(
        .ACC_W (ACC_W),
        .ADDR_W(ADDR_W)
    ) stage_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .stage_word(stage_word)
    );

    nco_dither_gen #(
        .LFSR_W(LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .DIV   (DITHER_DIV),
        .AMP   (DITHER_AMP),
        .OFF_W (OFF_W)
    ) dither_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .dither_off(dither_off)
    );

    nco_phase_core #(
        .ACC_W(ACC_W),
        .AMP  (DITHER_AMP),
        .OFF_W(OFF_W)
    ) core_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .stage_word(stage_word),
        .latch_req (latch_req),
        .dither_en (dither_en),
        .dither_off(dither_off),
        .freq_word (freq_word),
        .phase_msb (phase_msb),
        .wrap_pulse(wrap_pulse),
        .latch_pend(latch_pend)
    );

endmodule

// File: tb/nco_clk_synth_tb.sv
`timescale 1ns/1ps
module nco_clk_synth_tb_top;

    localparam int DIV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        latch_req = 1'b0;
    logic        dither_en = 1'b0;
    logic [23:0] freq_word;
    logic        phase_msb;
    logic        wrap_pulse;
    logic        latch_pend;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [23:0] m_acc, m_act, m_stage;
    logic        m_pend, m_wrap;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    nco_clk_synth #(.DITHER_DIV(DIV)) dut_i (
        .clk_ref    (clk_ref_w),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data),
        .latch_req  (latch_req),
        .dither_en  (dither_en),
        .freq_word  (freq_word),
        .phase_msb  (phase_msb),
        .wrap_pulse (wrap_pulse),
        .latch_pend (latch_pend)
    );

    wire clk_ref_w = clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] lfsr_after(input int n);
        logic [15:0] s = 16'hACE1;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return s;
    endfunction

    function automatic logic [23:0] dithered(input logic [23:0] a, input int n);
        int v = int'(lfsr_after(n) & 16'h7);
        return a + 24'((v % 5) - 2);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr_en = 1'b0; latch_req = 1'b0; dither_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0; m_act = '0; m_stage = '0; m_pend = 1'b0; m_wrap = 1'b0;
    endtask

    // One reference cycle with the model advanced at the rising edge (dither off).
    task automatic cycle(input logic we, input logic [1:0] addr, input logic [7:0] data,
                         input logic lat, input string req);
        logic [24:0] sum;
        logic        idle, xfer;
        reg_wr_en = we; reg_wr_addr = addr; reg_wr_data = data; latch_req = lat;
        @(posedge clk);
        idle = (m_act == '0);
        sum  = {1'b0, m_acc} + {1'b0, m_act};
        xfer = m_pend && (sum[24] || idle);
        m_wrap = sum[24];
        m_acc  = idle ? 24'h0 : sum[23:0];
        m_pend = lat || (m_pend && !xfer);
        if (xfer) m_act = m_stage;
        if (we && addr < 2'd3) m_stage[addr*8 +: 8] = data;
        @(negedge clk);
        chk(req, {5'b0, freq_word, phase_msb, wrap_pulse, latch_pend},
                 {5'b0, m_act, m_acc[23], m_wrap, m_pend});
        reg_wr_en = 1'b0; latch_req = 1'b0;
    endtask

    task automatic stage_word(input logic [23:0] w, input string req);
        for (int b = 0; b < 3; b++) cycle(1'b1, 2'(b), w[b*8 +: 8], 1'b0, req);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 8'h00, 1'b0, req);
    endtask

    task automatic wait_cyc(input int target);
        while (cyc != target) @(negedge clk);
    endtask

    task automatic dither_run(input logic [23:0] w, input bit in_range, input string req);
        do_reset();
        stage_word(w, req);
        cycle(1'b0, 2'd0, 8'h00, 1'b1, req);
        cycle(1'b0, 2'd0, 8'h00, 1'b0, req);
        dither_en = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            wait_cyc(n*DIV + DIV/2);
            chk(req, {8'b0, freq_word}, {8'b0, in_range ? dithered(w, n) : w});
        end
    endtask

    initial begin
        do_reset();
        // R1: reset state and idle until first latch
        chk("R1", {8'b0, freq_word}, 32'h0);
        chk("R1", {31'b0, phase_msb}, 32'h0);
        chk("R1", {31'b0, wrap_pulse}, 32'h0);
        chk("R1", {31'b0, latch_pend}, 32'h0);
        run(20, "R1");

        // R2 byte order, R3 out-of-range address, R4 idle transfer
        stage_word(24'h100000, "R2");
        cycle(1'b1, 2'd3, 8'hFF, 1'b0, "R3");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R4");
        cycle(1'b0, 2'd0, 8'h00, 1'b0, "R4");
        chk("R2", {8'b0, freq_word}, 32'h100000);
        run(200, "R6");

        // R5/R7: transfers at wraps with phase continuity, several word patterns
        stage_word(24'h0C0000, "R2");
        run(5, "R2");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        run(100, "R7");
        stage_word(24'h7FFFFF, "R2");
        cycle(1'b1, 2'd3, 8'h00, 1'b0, "R3");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        run(60, "R7");
        stage_word(24'hFFFFFF, "R2");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        run(40, "R6");
        stage_word(24'h555555, "R2");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        run(40, "R7");
        stage_word(24'h012345, "R2");
        cycle(1'b0, 2'd0, 8'h00, 1'b1, "R5");
        run(600, "R6");

        // R8/R9/R10: dither sequence, bounds and disable
        dither_run(24'h100000, 1'b1, "R8");
        dither_en = 1'b0;
        #1 chk("R10", {8'b0, freq_word}, 32'h100000);
        wait_cyc(8*DIV + DIV/2);
        chk("R10", {8'b0, freq_word}, 32'h100000);
        dither_run(24'h000002, 1'b0, "R9");
        dither_run(24'h000003, 1'b1, "R9");
        dither_run(24'hFFFFFE, 1'b0, "R9");
        dither_run(24'hFFFFFD, 1'b1, "R9");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule